// File: doc/BRIEF.md
# Coherent-Clock Synchronizer Delay Calibrator

This block tunes a selectable delay placed on a data path that crosses between two clock domains derived from one reference. With a rational frequency ratio of the form N + P/Q, data edges land at only Q distinct phases inside the receive-clock period. These phases are spaced evenly. If one of them coincides with the sampling point of the first synchronizer flip-flop, metastable events become far more frequent than the uniform-phase estimate predicts. The calibrator moves the data so that the sampling point falls midway between two neighbouring phase clusters, and then holds that setting.

The controller runs in the receive-clock domain. Besides the synchronizer's first-stage output it takes a second sample of the same data, taken a little later. Whenever the two disagree, the cycle counts as a suspect event. After reset, the controller steps the tap select through every tap of a 2^K-tap delay line. It counts suspect events over a fixed window of cycles at each tap. The tap with the highest count marks a phase cluster sitting on the sampling point. The controller then adds half the cluster spacing, which is the tap count divided by 2Q, wraps the result modulo the tap count, applies it and raises `locked`. A relock request restarts the sweep. The synchronizer chain itself stays an ordinary flip-flop chain outside this block.

Top module: `cdc_delay_cal`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next outputs are `tap_sel` = 0 and `locked` = 0. The reset is synchronous and active low.
- R2: After reset, the sweep holds each tap for exactly WIN_CYCLES edges, in ascending order from 0 to TAPS-1. `tap_sel` equals k right after edge k*WIN_CYCLES, counting the first edge with `rst_n` high as edge 0. `tap_sel` never changes in the middle of a window.
- R3: A suspect event is any sampled edge where `s1_q` differs from `s1_late`. Each tap's score is the number of such edges in its window.
- R4: The locked tap is (peak + floor(TAPS / (2*Q))) mod TAPS. Here peak is the tap with the highest score and Q is `q_den` as sampled after the sweep.
- R5: When several taps share the highest score, the lowest-numbered tap counts as the peak.
- R6: When every tap scores zero, the locked tap is TAPS/2 and `locked` still rises.
- R7: `locked` rises exactly TAPS*WIN_CYCLES+2 edges after edge 0 of R2. Until then it stays low.
- R8: While `locked` is high, `tap_sel` does not change. Suspect events and changes of `q_den` have no effect on it.
- R9: A `relock` high at an edge while locked clears `locked` and sets `tap_sel` to 0 at that edge. The full sweep then restarts, and `locked` rises TAPS*WIN_CYCLES+2 edges later.
- R10: `relock` is ignored outside the locked state. A pulse during the sweep leaves the R7 timing and the R4 result unchanged.
- R11: A `q_den` of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive-domain clock |
| rst_n | input | 1 | Synchronous active-low reset; calibration starts after it |
| relock | input | 1 | Frequency-change request; restarts calibration when locked |
| q_den | input | Q_W | Denominator Q of the clock ratio N + P/Q |
| s1_q | input | 1 | Output of the first synchronizer flip-flop |
| s1_late | input | 1 | Delayed re-sample of the same data |
| tap_sel | output | TAP_W | Delay-line tap select |
| locked | output | 1 | High once the chosen tap has been applied |

## Verification
Every result of this block has a fixed cycle count. Counting from the first edge with reset released, tap k begins after edge k*WIN_CYCLES, the final tap is applied and `locked` rises after edge TAPS*WIN_CYCLES+2, and reset or an accepted relock takes effect at the edge that samples it. The bench counts rising edges itself and samples one time unit after each edge. It compares the edge index where `locked` first reads high against these numbers, and it checks the tap order at each window start. The bench's delay-line model derives the suspect pattern from the current tap, so each tap's score is known exactly in advance.

// File: rtl/cdc_cal_pkg.sv
// Package: shared types for the delay calibrator.
// Assumes: nothing beyond IEEE 1800-2017.
package cdc_cal_pkg;
    typedef enum logic [2:0] {
        CAL_IDLE   = 3'd0,
        CAL_SWEEP  = 3'd1,
        CAL_EVAL   = 3'd2,
        CAL_APPLY  = 3'd3,
        CAL_LOCKED = 3'd4
    } cal_state_e;
endpackage

// File: rtl/cal_window_counter.sv
// Counts suspect events over a window of WIN_CYCLES sampled edges.
// The window advances only while run is high and restarts on clear or
// after its last cycle. ev_total includes the current cycle's event.
// Assumes: WIN_CYCLES >= 2.
module cal_window_counter #(
    parameter int WIN_CYCLES = 64,
    parameter int WIN_W      = $clog2(WIN_CYCLES),
    parameter int CNT_W      = $clog2(WIN_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             suspect,
    output logic             win_last,
    output logic [CNT_W-1:0] ev_total,
    output logic [WIN_W-1:0] win_pos
);
    localparam logic [WIN_W-1:0] LAST = WIN_W'(WIN_CYCLES - 1);

    logic [WIN_W-1:0] win_q;
    logic [CNT_W-1:0] ev_q;

    // Window end flag and running total including this cycle.
    always_comb begin
        win_last = run && (win_q == LAST);
        ev_total = ev_q + CNT_W'(suspect);
        win_pos  = win_q;
    end

    // Position and event accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || win_last) begin
            win_q <= '0;
            ev_q  <= '0;
        end else if (run) begin
            win_q <= win_q + 1'b1;
            ev_q  <= ev_total;
        end
    end
endmodule

// File: rtl/cal_peak_tracker.sv
// Keeps the tap with the highest window score seen since the last clear.
// Strict comparison keeps the earliest (lowest) tap on ties.
// Assumes: taps are presented in ascending order.
module cal_peak_tracker #(
    parameter int TAP_W = 4,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample,
    input  logic [TAP_W-1:0] tap,
    input  logic [CNT_W-1:0] count,
    output logic [TAP_W-1:0] best_tap,
    output logic             best_zero
);
    logic [CNT_W-1:0] best_cnt_q;
    logic [TAP_W-1:0] best_tap_q;

    // Record a new maximum at the end of each window.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            best_cnt_q <= '0;
            best_tap_q <= '0;
        end else if (sample && (count > best_cnt_q)) begin
            best_cnt_q <= count;
            best_tap_q <= tap;
        end
    end

    // Expose the result.
    always_comb begin
        best_tap  = best_tap_q;
        best_zero = (best_cnt_q == '0);
    end
endmodule

// File: rtl/cal_tap_pick.sv
// Computes the lock target: peak tap plus half the cluster spacing,
// TAPS/(2Q) rounded down, modulo TAPS. If nothing was seen, the middle tap.
// Assumes: TAPS is a power of two, so the wrap is a truncation.
module cal_tap_pick #(
    parameter int TAP_W = 4,
    parameter int Q_W   = 4
) (
    input  logic [Q_W-1:0]   q_den,
    input  logic [TAP_W-1:0] peak_tap,
    input  logic             none_seen,
    output logic [TAP_W-1:0] target
);
    localparam int TAPS = 1 << TAP_W;
    localparam int W    = TAP_W + Q_W + 2;
    localparam logic [TAP_W-1:0] MID = TAP_W'(TAPS / 2);

    logic [W-1:0] num, den, half_gap, sum;

    // Half-spacing offset and wrapped target.
    always_comb begin
        num      = W'(TAPS);
        den      = (q_den == '0) ? W'(2) : (W'(q_den) << 1);
        half_gap = num / den;
        sum      = W'(peak_tap) + half_gap;
        target   = none_seen ? MID : sum[TAP_W-1:0];
    end
endmodule

// File: rtl/cdc_delay_cal.sv
// Top: sweeps the delay taps, scores each by suspect events, picks the tap
// half a phase-cluster spacing from the worst one, applies and locks it.
// Assumes: s1_q and s1_late are already in the clk domain.
module cdc_delay_cal #(
    parameter int TAP_W      = 4,
    parameter int WIN_CYCLES = 64,
    parameter int Q_W        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             relock,
    input  logic [Q_W-1:0]   q_den,
    input  logic             s1_q,
    input  logic             s1_late,
    output logic [TAP_W-1:0] tap_sel,
    output logic             locked
);
    import cdc_cal_pkg::*;

    localparam int WIN_W = $clog2(WIN_CYCLES);
    localparam int CNT_W = $clog2(WIN_CYCLES + 1);
    localparam logic [TAP_W-1:0] TAP_MAX = '1;

    cal_state_e       st_q;
    logic [TAP_W-1:0] tap_q, target_q, pick;
    logic             locked_q;
    logic             suspect, win_last, best_zero, peak_clear;
    logic [CNT_W-1:0] ev_total;
    logic [WIN_W-1:0] win_q;
    logic [TAP_W-1:0] best_tap;

    // Suspect detection and sub-block controls.
    always_comb begin
        suspect    = s1_q ^ s1_late;
        peak_clear = (st_q == CAL_IDLE) || (st_q == CAL_LOCKED);
    end

    cal_window_counter #(.WIN_CYCLES(WIN_CYCLES), .WIN_W(WIN_W), .CNT_W(CNT_W)) u_win (
        .clk(clk), .rst_n(rst_n), .clear(st_q != CAL_SWEEP),
        .run(st_q == CAL_SWEEP), .suspect(suspect),
        .win_last(win_last), .ev_total(ev_total), .win_pos(win_q)
    );

    cal_peak_tracker #(.TAP_W(TAP_W), .CNT_W(CNT_W)) u_peak (
        .clk(clk), .rst_n(rst_n), .clear(peak_clear), .sample(win_last),
        .tap(tap_q), .count(ev_total), .best_tap(best_tap), .best_zero(best_zero)
    );

    cal_tap_pick #(.TAP_W(TAP_W), .Q_W(Q_W)) u_pick (
        .q_den(q_den), .peak_tap(best_tap), .none_seen(best_zero), .target(pick)
    );

    // Calibration sequence: idle, sweep, evaluate, apply, locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= CAL_IDLE;
            tap_q    <= '0;
            target_q <= '0;
            locked_q <= 1'b0;
        end else begin
            case (st_q)
                CAL_IDLE: begin
                    st_q  <= CAL_SWEEP;
                    tap_q <= '0;
                end
                CAL_SWEEP: begin
                    if (win_last) begin
                        if (tap_q == TAP_MAX) st_q <= CAL_EVAL;
                        else                  tap_q <= tap_q + 1'b1;
                    end
                end
                CAL_EVAL: begin
                    target_q <= pick;
                    st_q     <= CAL_APPLY;
                end
                CAL_APPLY: begin
                    tap_q    <= target_q;
                    locked_q <= 1'b1;
                    st_q     <= CAL_LOCKED;
                end
                CAL_LOCKED: begin
                    if (relock) begin
                        st_q     <= CAL_SWEEP;
                        tap_q    <= '0;
                        locked_q <= 1'b0;
                    end
                end
                default: st_q <= CAL_IDLE;
            endcase
        end
    end

    // Output drive.
    always_comb begin
        tap_sel = tap_q;
        locked  = locked_q;
    end
endmodule

// File: rtl/cdc_delay_cal_chk.sv
// Checker for cdc_delay_cal, attached by bind. Watches ports and the
// controller state and window position.
module cdc_delay_cal_chk #(
    parameter int TAP_W = 4,
    parameter int WIN_W = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   relock,
    input logic [TAP_W-1:0]       tap_sel,
    input logic                   locked,
    input cdc_cal_pkg::cal_state_e st,
    input logic [WIN_W-1:0]       win_pos
);
    import cdc_cal_pkg::*;

    // R8: tap held while locked
    a_r8_tap_stable_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> (tap_sel == $past(tap_sel)));

    // R2: no tap change inside a window
    a_r2_no_midwindow_change: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CAL_SWEEP && win_pos != '0) |-> $stable(tap_sel));

    // R9: accepted relock drops lock and rewinds the tap
    a_r9_relock_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CAL_LOCKED && relock) |=> (!locked && tap_sel == '0));

    // R7: locked only in the locked state
    a_r7_locked_state: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (st == CAL_LOCKED));

    // R4: apply step is followed by lock
    a_r4_apply_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CAL_APPLY) |=> locked);
endmodule

bind cdc_delay_cal cdc_delay_cal_chk #(.TAP_W(TAP_W), .WIN_W($clog2(WIN_CYCLES))) u_chk (
    .clk(clk), .rst_n(rst_n), .relock(relock), .tap_sel(tap_sel),
    .locked(locked), .st(st_q), .win_pos(win_q)
);

// File: tb/sim_cdc_delay_cal.sv
module sim_cdc_delay_cal;
    localparam int TAP_W = 4;
    localparam int TAPS  = 1 << TAP_W;
    localparam int WIN   = 64;
    localparam int Q_W   = 4;
    localparam int LAT_RST   = TAPS * WIN + 3;
    localparam int LAT_RELOCK = TAPS * WIN + 2;

    logic clk = 0;
    logic rst_n = 0;
    logic relock = 0;
    logic [Q_W-1:0] q_den = 4'd1;
    logic s1_q, s1_late, hit;
    logic [TAP_W-1:0] tap_sel;
    logic locked;

    int checks = 0;
    int errors = 0;
    int bcnt = 0;
    int weights [TAPS];

    always #4 clk = ~clk;

    cdc_delay_cal #(.TAP_W(TAP_W), .WIN_CYCLES(WIN), .Q_W(Q_W)) u0 (
        .clk(clk), .rst_n(rst_n), .relock(relock), .q_den(q_den),
        .s1_q(s1_q), .s1_late(s1_late), .tap_sel(tap_sel), .locked(locked)
    );

    // Delay-line model: tap weight w gives 8*w suspect edges per window (R3).
    always @(negedge clk) bcnt <= bcnt + 1;
    always_comb begin
        hit     = (weights[tap_sel] > (bcnt % 8));
        s1_q    = bcnt[1];
        s1_late = s1_q ^ hit;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_weights();
        for (int i = 0; i < TAPS; i++) weights[i] = 0;
    endtask

    // Hold reset, check reset outputs (R1), release at a falling edge.
    task automatic do_reset();
        @(negedge clk) rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        check(tap_sel == 0 && locked == 0, "R1 reset outputs", {tap_sel, locked}, 0);
        @(negedge clk) rst_n = 1;
    endtask

    // Count edges until locked; check latency, final tap and optionally order.
    task automatic wait_lock(input int exp_n, input int exp_tap, input string req,
                             input bit chk_order, input int pulse_at);
        int n = 0;
        int bad = 0;
        int first_bad = -1;
        for (int i = 1; i <= 3 * LAT_RST; i++) begin
            @(posedge clk);
            #1;
            n = i;
            if (relock) relock = 0;
            if (chk_order && ((i - 1) % WIN == 0) && ((i - 1) / WIN < TAPS)) begin
                if (tap_sel != (i - 1) / WIN) begin
                    bad++;
                    if (first_bad < 0) first_bad = i;
                end
            end
            if (i == pulse_at) relock = 1;
            if (locked) break;
        end
        if (chk_order)
            check(bad == 0, "R2 sweep order", first_bad, -1);
        check(n == exp_n, {req, " R7 lock latency"}, n, exp_n);
        check(tap_sel == exp_tap, {req, " chosen tap"}, tap_sel, exp_tap);
    endtask

    // Accepted relock from locked (R9).
    task automatic do_relock();
        @(negedge clk) relock = 1;
        @(posedge clk);
        #1;
        relock = 0;
        check(locked == 0 && tap_sel == 0, "R9 relock clears", {tap_sel, locked}, 0);
    endtask

    task automatic t_single_peak();
        clear_weights();
        weights[2] = 2; weights[3] = 6; weights[4] = 3;
        q_den = 4'd2;
        do_reset();
        wait_lock(LAT_RST, 7, "R4 peak3 Q2", 1, 0);
    endtask

    task automatic t_relock_wrap();
        clear_weights();
        weights[14] = 5; weights[1] = 2;
        q_den = 4'd1;
        do_relock();
        wait_lock(LAT_RELOCK, 6, "R9 R4 wrap peak14 Q1", 0, 0);
    endtask

    task automatic t_tie();
        clear_weights();
        weights[5] = 4; weights[9] = 4;
        q_den = 4'd4;
        do_reset();
        wait_lock(LAT_RST, 7, "R5 tie", 0, 0);
    endtask

    task automatic t_zero();
        clear_weights();
        q_den = 4'd3;
        do_reset();
        wait_lock(LAT_RST, TAPS / 2, "R6 no events", 0, 0);
        check(locked == 1, "R6 locked", locked, 1);
    endtask

    task automatic t_q_edge();
        clear_weights();
        weights[2] = 8;
        q_den = 4'd0;
        do_reset();
        wait_lock(LAT_RST, 10, "R11 Q0", 0, 0);
        clear_weights();
        weights[15] = 7; weights[0] = 1;
        q_den = 4'd5;
        do_relock();
        wait_lock(LAT_RELOCK, 0, "R4 peak15 Q5", 0, 0);
    endtask

    task automatic t_ignored();
        logic [TAP_W-1:0] held;
        clear_weights();
        weights[1] = 3;
        q_den = 4'd8;
        do_reset();
        wait_lock(LAT_RST, 2, "R10 relock mid-sweep", 0, 300);
        held = tap_sel;
        clear_weights();
        for (int i = 0; i < TAPS; i++) weights[i] = 8;
        q_den = 4'd3;
        repeat (200) @(posedge clk);
        #1;
        check(tap_sel == held && locked == 1, "R8 locked holds", tap_sel, held);
    endtask

    task automatic t_reset_mid();
        clear_weights();
        weights[6] = 4;
        q_den = 4'd2;
        do_reset();
        repeat (500) @(posedge clk);
        @(negedge clk) rst_n = 0;
        @(posedge clk);
        #1;
        check(tap_sel == 0 && locked == 0, "R1 reset mid-sweep", {tap_sel, locked}, 0);
        @(negedge clk) rst_n = 1;
        wait_lock(LAT_RST, 10, "R1 restart after reset", 0, 0);
    endtask

    initial begin
        clear_weights();
        t_single_peak();
        t_relock_wrap();
        t_tie();
        t_zero();
        t_q_edge();
        t_ignored();
        t_reset_mid();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule